// File: doc/BRIEF.md
# Two-Source Interrupt Combiner

This block merges two interrupt sources, a fabric I/O event (bit 0) and a DMA completion (bit 1), into one registered interrupt request line. Each source may be a level or a pulse. A rising edge on a source latches a pending bit in a status register, whether or not that source is currently masked. The request line is raised when a pending bit is also enabled and the master enable is on.

Software reaches the block through a simple 32-bit register bus with a write strobe, a read strobe, an address and write data. The enable register can be written whole. It can also have bits turned on one at a time through a write-one set-enable location, so no read-modify-write sequence is needed. Pending bits are retired through a write-one acknowledge location. A single master enable bit gates the output without touching any other state. Read data is registered and appears in the cycle after the read strobe.

Top module: `irq_combiner`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears status, enable, master enable, the request output and the read data to zero.
- R2: A 0-to-1 change on src_i[0] (fabric I/O) or src_i[1] (DMA) sets status bit 0 or bit 1 on the next clock edge, whatever the enable bit holds. A source held high sets its bit only once.
- R3: A write to offset 0x0C (acknowledge) clears each status bit whose data bit is 1. Zero bits, and ones at bits that are not pending or not implemented, change nothing.
- R4: Offset 0x08 (enable) is read/write. A 1 at bit i enables source i and a 0 disables it. Bits 31..2 read as zero.
- R5: A write to offset 0x10 (set-enable) ORs data bits 1..0 into the enable register. Zero bits and bits 31..2 leave the enable register unchanged.
- R6: Offset 0x1C bit 0 is the master enable. While it is 0 the request output is 0.
- R7: irq_o is a register that takes master AND OR(status AND enable). It follows any change in those registers one clock later, which includes unmasking a bit that is already pending.
- R8: A read strobe loads rdata on the next edge: offset 0x00 returns status in bits 1..0, 0x08 returns enable, and 0x1C returns master in bit 0. The write-only offsets 0x0C and 0x10, and any other offset, return zero. Writes to 0x00 are ignored. rdata holds its value between reads.
- R9: If a source edge and an acknowledge of the same bit fall in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC (2) | Interrupt sources: bit 0 fabric I/O, bit 1 DMA |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW (8) | Register byte offset |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two things can land on the same status bit in one cycle: a new source edge and a software acknowledge of that bit. The bench provokes this by raising the DMA source in the same cycle as an acknowledge write to bit 1. Its behavioural model applies the clear before the set, so it expects the bit to stay pending, and both a status read and the request line are compared against that. The same per-cycle model also judges the milder overlap of a set-enable write that lands on a bit already pending, where the request must rise one cycle later.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_ACK,
    SEL_SETEN,
    SEL_MASTER
  } reg_sel_e;

  localparam logic [31:0] OFS_STATUS = 32'h00;
  localparam logic [31:0] OFS_ENABLE = 32'h08;
  localparam logic [31:0] OFS_ACK    = 32'h0C;
  localparam logic [31:0] OFS_SETEN  = 32'h10;
  localparam logic [31:0] OFS_MASTER = 32'h1C;

  function automatic reg_sel_e decode_sel(input logic [31:0] a);
    reg_sel_e s;
    case (a)
      OFS_STATUS: s = SEL_STATUS;
      OFS_ENABLE: s = SEL_ENABLE;
      OFS_ACK:    s = SEL_ACK;
      OFS_SETEN:  s = SEL_SETEN;
      OFS_MASTER: s = SEL_MASTER;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/irqc_edge_det.sv
module irqc_edge_det #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] rise_o
);

  logic [NSRC-1:0] src_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q[g] <= 1'b0;
      else        src_q[g] <= src_i[g];
    end
    assign rise_o[g] = src_i[g] & ~src_q[g];
  end

  // R2: a held source produces one event, never two in a row
  a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter int NSRC = 2,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  reg_sel_e        sel,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] rise_i,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] enable_o,
  output logic            master_o,
  output logic [DW-1:0]   rdata_o
);

  logic [NSRC-1:0] status_q, enable_q;
  logic            master_q;
  logic [DW-1:0]   rdata_q;

  // Named internal events, used by the assertions
  logic [NSRC-1:0] ack_w;
  logic            enwr_w, seten_w, mwr_w;

  // Clear first, then set: a coincident edge survives the acknowledge
  function automatic logic [NSRC-1:0] next_status(input logic [NSRC-1:0] cur,
                                                  input logic [NSRC-1:0] clr,
                                                  input logic [NSRC-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [DW-1:0] read_mux(input reg_sel_e s,
                                             input logic [NSRC-1:0] st,
                                             input logic [NSRC-1:0] en,
                                             input logic ms);
    logic [DW-1:0] v;
    v = '0;
    case (s)
      SEL_STATUS: v[NSRC-1:0] = st;
      SEL_ENABLE: v[NSRC-1:0] = en;
      SEL_MASTER: v[0]        = ms;
      default:    v           = '0;
    endcase
    return v;
  endfunction

  assign ack_w   = (wr_en && sel == SEL_ACK) ? wdata[NSRC-1:0] : '0;
  assign enwr_w  = wr_en && sel == SEL_ENABLE;
  assign seten_w = wr_en && sel == SEL_SETEN;
  assign mwr_w   = wr_en && sel == SEL_MASTER;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      master_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      status_q <= next_status(status_q, ack_w, rise_i);
      if (enwr_w)       enable_q <= wdata[NSRC-1:0];
      else if (seten_w) enable_q <= enable_q | wdata[NSRC-1:0];
      if (mwr_w)        master_q <= wdata[0];
      if (rd_en)        rdata_q  <= read_mux(sel, status_q, enable_q, master_q);
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign master_o = master_q;
  assign rdata_o  = rdata_q;

  // R9: an edge always leaves its bit pending, even under acknowledge
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((status_q & $past(rise_i)) == $past(rise_i)));

  // R3: acknowledged bits with no new edge are cleared
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_w & ~rise_i)) |=> ((status_q & $past(ack_w & ~rise_i)) == '0));

  // R5: set-enable never drops an enable bit
  a_r5_seten_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    seten_w |=> ((enable_q & $past(enable_q)) == $past(enable_q)));

  // R8: write-only locations read back as zero
  a_r8_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (sel == SEL_ACK || sel == SEL_SETEN)) |=> (rdata_q == '0));

  // R4: reserved read bits stay zero
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_q[DW-1:NSRC] == '0);

endmodule

// File: rtl/irqc_req_out.sv
module irqc_req_out #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] status_i,
  input  logic [NSRC-1:0] enable_i,
  input  logic            master_i,
  output logic            irq_o
);

  logic irq_q;
  logic req_w;

  function automatic logic want_req(input logic [NSRC-1:0] st,
                                    input logic [NSRC-1:0] en,
                                    input logic ms);
    return ms & (|(st & en));
  endfunction

  assign req_w = want_req(status_i, enable_i, master_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= req_w;
  end

  assign irq_o = irq_q;

  // R6: master off forces the request low on the next cycle
  a_r6_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master_i |=> !irq_o);

  // R7: nothing pending and enabled means no request next cycle
  a_r7_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i & enable_i) == '0) |=> !irq_o);

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irqc_pkg::*;
#(
  parameter int NSRC = 2,
  parameter int DW   = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_o
);

  reg_sel_e        sel;
  logic [NSRC-1:0] rise, status, enable;
  logic            master;

  assign sel = decode_sel(32'(addr));

  irqc_edge_det #(.NSRC(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise)
  );

  irqc_regfile #(.NSRC(NSRC), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
    .wdata(wdata), .rise_i(rise), .status_o(status), .enable_o(enable),
    .master_o(master), .rdata_o(rdata)
  );

  irqc_req_out #(.NSRC(NSRC)) u_req (
    .clk(clk), .rst_n(rst_n), .status_i(status), .enable_i(enable),
    .master_i(master), .irq_o(irq_o)
  );

endmodule

// File: tb/irq_combiner_bench.sv
module irq_combiner_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src = 2'b00;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  string tag = "R1";

  always #2 clk = ~clk;  // 250 MHz

  irq_combiner u_irq_combiner (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr), .rd_en(rd),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq)
  );

  // Behavioural reference model, advanced on each rising edge
  int m_st = 0, m_en = 0, m_ms = 0, m_irq = 0, m_rd = 0, m_prev = 0;

  function automatic int model_read(int a, int st, int en, int ms);
    if (a == 0)    return st;
    if (a == 8)    return en;
    if (a == 28)   return ms;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_ms = 0; m_irq = 0; m_rd = 0; m_prev = 0;
    end else begin
      int rise, ack, n_irq, n_rd;
      rise  = int'(src) & ~m_prev & 3;
      ack   = (wr && addr == 8'h0C) ? int'(wdata[1:0]) : 0;
      n_irq = (m_ms != 0 && (m_st & m_en) != 0) ? 1 : 0;
      n_rd  = rd ? model_read(int'(addr), m_st, m_en, m_ms) : m_rd;
      m_st  = (m_st & ~ack) | rise;
      if (wr && addr == 8'h08) m_en = int'(wdata[1:0]);
      if (wr && addr == 8'h10) m_en = m_en | int'(wdata[1:0]);
      if (wr && addr == 8'h1C) m_ms = int'(wdata[0]);
      m_prev = int'(src);
      m_irq  = n_irq;
      m_rd   = n_rd;
    end
  end

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Advance to the next falling edge and compare against the model
  task automatic cyc();
    @(negedge clk);
    check({tag, " irq"}, int'(irq), m_irq);
    check({tag, " rdata"}, int'(rdata), m_rd);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    cyc();
    wr = 1'b0; wdata = 32'h0;
  endtask

  task automatic rd_expect(logic [7:0] a, int exp, string req);
    rd = 1'b1; addr = a;
    cyc();
    rd = 1'b0;
    check(req, int'(rdata), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset irq", int'(irq), 0);
    check("R1 reset rdata", int'(rdata), 0);
    rst_n = 1'b1;
    cyc();
    tag = "R1"; rd_expect(8'h00, 0, "R1 status zero");
    rd_expect(8'h08, 0, "R1 enable zero");
    rd_expect(8'h1C, 0, "R1 master zero");

    // R2: level source latches once, even while masked
    tag = "R2"; src = 2'b01;
    repeat (3) cyc();
    rd_expect(8'h00, 1, "R2 fabric pending while masked");
    check("R2 no irq while masked", int'(irq), 0);

    // R4: enable read/write, reserved bits read zero
    tag = "R4"; wr_reg(8'h08, 32'hFFFF_FFFF);
    rd_expect(8'h08, 3, "R4 enable reserved zero");
    wr_reg(8'h08, 32'h0);
    rd_expect(8'h08, 0, "R4 enable cleared");

    // R6: master off keeps irq low even with pending+enabled
    tag = "R6"; wr_reg(8'h10, 32'h1);
    cyc(); cyc();
    check("R6 master gates irq", int'(irq), 0);
    // R7: master on raises irq one cycle after the register
    tag = "R7"; wr_reg(8'h1C, 32'h1);
    cyc();
    check("R7 irq after master", int'(irq), 1);
    rd_expect(8'h1C, 1, "R8 master readback");

    // R3: acknowledge behaviour
    tag = "R3"; wr_reg(8'h0C, 32'h0);
    rd_expect(8'h00, 1, "R3 zero ack no effect");
    wr_reg(8'h0C, 32'hFFFF_FFFE);
    rd_expect(8'h00, 1, "R3 ack of idle bit no effect");
    wr_reg(8'h0C, 32'h1);
    cyc();
    check("R3 irq drops after ack", int'(irq), 0);
    rd_expect(8'h00, 0, "R3 status cleared");
    repeat (2) cyc();
    rd_expect(8'h00, 0, "R2 held level no re-set");
    src = 2'b00;

    // R5: set-enable
    tag = "R5"; wr_reg(8'h10, 32'h0);
    rd_expect(8'h08, 1, "R5 zeros keep enable");
    wr_reg(8'h10, 32'hFFFF_FFFC);
    rd_expect(8'h08, 1, "R5 reserved bits no effect");

    // R7: pulse on DMA while masked, then unmask pending bit
    tag = "R7"; src = 2'b10; cyc(); src = 2'b00; cyc();
    check("R7 dma masked no irq", int'(irq), 0);
    wr_reg(8'h10, 32'h2);
    cyc();
    check("R7 unmask pending raises irq", int'(irq), 1);
    rd_expect(8'h08, 3, "R5 set-enable ORs in");
    wr_reg(8'h0C, 32'h2);

    // R9: DMA edge in the same cycle as its acknowledge
    tag = "R9"; src = 2'b10;
    wr_reg(8'h0C, 32'h2);
    src = 2'b00;
    rd_expect(8'h00, 2, "R9 set wins over ack");
    cyc();
    check("R9 irq stays", int'(irq), 1);

    // R8: read map and ignored writes
    tag = "R8"; wr_reg(8'h00, 32'h0);
    rd_expect(8'h00, 2, "R8 status write ignored");
    rd_expect(8'h0C, 0, "R8 ack reads zero");
    rd_expect(8'h10, 0, "R8 seten reads zero");
    rd_expect(8'h04, 0, "R8 unmapped reads zero");
    rd_expect(8'h08, 3, "R8 enable read");
    cyc();
    check("R8 rdata holds", int'(rdata), 3);

    // R6: master off drops irq while bit stays pending
    tag = "R6"; wr_reg(8'h1C, 32'h0);
    cyc();
    check("R6 master off drops irq", int'(irq), 0);

    // R1: reset mid-run clears everything
    tag = "R1"; rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset irq", int'(irq), 0);
    rst_n = 1'b1;
    rd_expect(8'h00, 0, "R1 status after reset");
    rd_expect(8'h08, 0, "R1 enable after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule